// File: doc/BRIEF.md
# Host-Bridge Configuration Register Space

This block holds the 256-byte configuration space of a host-bridge function. A bus-side agent reaches it through a plain byte port: a function number, an 8-bit register offset, a write strobe, write data and combinational read data. Each byte has its own update rule. Some bytes are constant, one byte clears bits when ones are written to it, a set of bytes accept writes only in selected bit positions, and every other byte takes the whole written value.

A hard reset loads the power-on image in one cycle: identification, command, status, revision, class, non-cacheable control, DRAM configuration and bank-ending values. A separate soft-reset input only drops the system-BIOS shadow field (bits 5:4 of offset 0x63) back to zero. The three shadow-control bytes at offsets 0x61, 0x62 and 0x63 are also sent out raw on a dedicated bus, so that a memory-map decoder elsewhere can use them without going through the read port.

Top module: `hb_cfg_space`

## Requirements
- R1: After hard reset, offsets 0x00..0x03 read 0x06, 0x11, 0x95, 0x15; 0x04 reads 0x07; 0x06/0x07 read 0xA0/0x02; 0x08 reads 0x02; 0x0B reads 0x06; 0x52 reads 0x02; 0x58 reads 0x40; 0x59 reads 0x05; each of 0x5A..0x5F reads 0x01; 0x64 reads 0xAB.
- R2: After hard reset, every offset not named in R1 reads 0x00.
- R3: Writes to offsets 0x00, 0x01, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0E and 0x0F leave them unchanged.
- R4: At offset 0x04 a write changes bit 6 only. All other bits keep their value.
- R5: At offset 0x07 writing a one to bit 7, 5 or 4 clears that bit. Zeros written there, and any value written to the other bits, change nothing.
- R6: The write masks are 0x20 at 0x65, 0x05 at 0x66, 0xC0 at 0x67, 0x40 at 0x68, 0x6F at 0x6D, 0x01 at 0x70, 0x4E at 0x71, 0x0C at 0x73 and 0xC7 at 0x75. Masked bits take the written data and unmasked bits keep their old value.
- R7: Every other offset takes the full written byte on the clock edge where the write strobe is high. The new value is readable right after that edge.
- R8: With a function number of 0, read data is the addressed byte, with no clock delay. With any other function number, read data is 0xFF.
- R9: A soft-reset cycle clears bits 5:4 of offset 0x63 and changes nothing else. If a write to 0x63 happens in the same cycle, the written value is applied first and bits 5:4 are then cleared.
- R10: shadow_ctl[7:0], [15:8] and [23:16] always equal the stored bytes at 0x61, 0x62 and 0x63.
- R11: The write path does not decode the function number. A write with a non-zero function number updates the addressed byte by the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous soft reset that clears the BIOS shadow field |
| fn_sel | input | FN_W | Function number of the access |
| reg_addr | input | 8 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| shadow_ctl | output | 24 | Raw shadow-control bytes (0x61 low, 0x63 high) |

## Verification
The assertions take reg_addr, wr_data, fn_sel and soft_rst to be known, stable values at every rising edge once reset has been released, and they treat each cycle as at most one write. The stimulus changes every input only on falling edges. It holds wr_en low during reset and for several cycles after release. It draws addresses over the full 8-bit range, half of them from the offsets that have special rules. Soft resets are placed both alone and in the same cycle as a write.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;
  localparam int CFG_AW = 8;
  localparam int CFG_N  = 1 << CFG_AW;

  function automatic logic [7:0] cfg_default(input logic [7:0] a);
    case (a)
      8'h00: return 8'h06;
      8'h01: return 8'h11;
      8'h02: return 8'h95;
      8'h03: return 8'h15;
      8'h04: return 8'h07;
      8'h06: return 8'hA0;
      8'h07: return 8'h02;
      8'h08: return 8'h02;
      8'h0B: return 8'h06;
      8'h52: return 8'h02;
      8'h58: return 8'h40;
      8'h59: return 8'h05;
      8'h5A, 8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h5F: return 8'h01;
      8'h64: return 8'hAB;
      default: return 8'h00;
    endcase
  endfunction

  // bits that take written data directly
  function automatic logic [7:0] cfg_wmask(input logic [7:0] a);
    case (a)
      8'h00, 8'h01, 8'h08, 8'h09, 8'h0A,
      8'h0B, 8'h0C, 8'h0E, 8'h0F: return 8'h00;
      8'h04: return 8'h40;
      8'h07: return 8'h00;
      8'h65: return 8'h20;
      8'h66: return 8'h05;
      8'h67: return 8'hC0;
      8'h68: return 8'h40;
      8'h6D: return 8'h6F;
      8'h70: return 8'h01;
      8'h71: return 8'h4E;
      8'h73: return 8'h0C;
      8'h75: return 8'hC7;
      default: return 8'hFF;
    endcase
  endfunction

  // bits cleared by writing one
  function automatic logic [7:0] cfg_w1c(input logic [7:0] a);
    return (a == 8'h07) ? 8'hB0 : 8'h00;
  endfunction

  // bits cleared by soft reset
  function automatic logic [7:0] cfg_sclr(input logic [7:0] a);
    return (a == 8'h63) ? 8'h30 : 8'h00;
  endfunction

  function automatic logic cfg_is_const(input logic [7:0] a);
    return (cfg_wmask(a) == 8'h00) && (cfg_w1c(a) == 8'h00) &&
           (cfg_sclr(a) == 8'h00);
  endfunction
endpackage

// File: rtl/hb_cfg_rst_sync.sv
module hb_cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/hb_cfg_cell.sv
module hb_cfg_cell #(
  parameter logic [7:0] DEFAULT = 8'h00,
  parameter logic [7:0] WMASK   = 8'hFF,
  parameter logic [7:0] W1C     = 8'h00,
  parameter logic [7:0] SCLR    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic       soft_rst,
  input  logic [7:0] wr_data,
  output logic [7:0] q
);
  localparam logic HAS_SCLR = (SCLR != 8'h00);

  logic [7:0] wr_val;
  logic [7:0] nxt;
  logic       en;

  always_comb begin
    wr_val = (q & ~WMASK) | (wr_data & WMASK);
    wr_val = wr_val & ~(wr_data & W1C);
    nxt    = wr_hit ? wr_val : q;
    if (soft_rst) nxt = nxt & ~SCLR;
    en     = wr_hit | (soft_rst & HAS_SCLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= DEFAULT;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/hb_cfg_rdmux.sv
module hb_cfg_rdmux #(
  parameter int FN_W = 3,
  parameter int N    = 256
) (
  input  logic [FN_W-1:0]     fn_sel,
  input  logic [7:0]          reg_addr,
  input  logic [N-1:0][7:0]   bytes,
  output logic [7:0]          rd_data
);
  always_comb begin
    if (fn_sel != '0) rd_data = 8'hFF;
    else              rd_data = bytes[reg_addr];
  end
endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
  import hb_cfg_pkg::*;
#(
  parameter int FN_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic [FN_W-1:0] fn_sel,
  input  logic [7:0]      reg_addr,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  output logic [23:0]     shadow_ctl
);
  localparam logic [7:0] SHADOW_BASE = 8'h61;
  localparam int         SHADOW_N    = 3;

  logic                   rst_sync_n;
  logic [CFG_N-1:0][7:0]  cfg_q;

  hb_cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < CFG_N; i++) begin : g_byte
    localparam logic [7:0] OFS = 8'(i);
    if (cfg_is_const(OFS)) begin : g_const
      assign cfg_q[i] = cfg_default(OFS);
    end else begin : g_reg
      logic hit;
      assign hit = wr_en && (reg_addr == OFS);
      hb_cfg_cell #(
        .DEFAULT (cfg_default(OFS)),
        .WMASK   (cfg_wmask(OFS)),
        .W1C     (cfg_w1c(OFS)),
        .SCLR    (cfg_sclr(OFS))
      ) u_cell (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .wr_hit   (hit),
        .soft_rst (soft_rst),
        .wr_data  (wr_data),
        .q        (cfg_q[i])
      );
    end
  end

  hb_cfg_rdmux #(.FN_W(FN_W), .N(CFG_N)) u_rd (
    .fn_sel   (fn_sel),
    .reg_addr (reg_addr),
    .bytes    (cfg_q),
    .rd_data  (rd_data)
  );

  for (genvar s = 0; s < SHADOW_N; s++) begin : g_shadow
    assign shadow_ctl[8*s +: 8] = cfg_q[int'(SHADOW_BASE) + s];
  end
endmodule

// File: rtl/hb_cfg_space_chk.sv
module hb_cfg_space_chk
  import hb_cfg_pkg::*;
#(
  parameter int FN_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  soft_rst,
  input logic [FN_W-1:0]       fn_sel,
  input logic [7:0]            reg_addr,
  input logic                  wr_en,
  input logic [7:0]            wr_data,
  input logic [7:0]            rd_data,
  input logic [23:0]           shadow_ctl,
  input logic [CFG_N-1:0][7:0] regs
);
  logic ro_hit;
  always_comb begin
    case (reg_addr)
      8'h00, 8'h01, 8'h08, 8'h09, 8'h0A,
      8'h0B, 8'h0C, 8'h0E, 8'h0F: ro_hit = 1'b1;
      default:                    ro_hit = 1'b0;
    endcase
  end

  assert_ro_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ro_hit) |=> (regs[$past(reg_addr)] == $past(regs[reg_addr])));

  assert_cmd_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 8'h04) |=>
      (regs[8'h04][6] == $past(wr_data[6])) &&
      ({regs[8'h04][7], regs[8'h04][5:0]} ==
       $past({regs[8'h04][7], regs[8'h04][5:0]})));

  assert_status_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 8'h07) |=>
      (regs[8'h07] == ($past(regs[8'h07]) & ~($past(wr_data) & 8'hB0))));

  assert_full_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == 8'h40) |=> (regs[8'h40] == $past(wr_data)));

  assert_fn_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel != '0) |-> (rd_data == 8'hFF));

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (regs[8'h63][5:4] == 2'b00));

  assert_soft_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr_en) |=>
      ({regs[8'h63][7:6], regs[8'h63][3:0]} ==
       $past({regs[8'h63][7:6], regs[8'h63][3:0]})) &&
      (regs[8'h64] == $past(regs[8'h64])));

  assert_shadow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_ctl == {regs[8'h63], regs[8'h62], regs[8'h61]});
endmodule

bind hb_cfg_space hb_cfg_space_chk #(.FN_W(FN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .soft_rst   (soft_rst),
  .fn_sel     (fn_sel),
  .reg_addr   (reg_addr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .shadow_ctl (shadow_ctl),
  .regs       (cfg_q)
);

// File: tb/tb_hb_cfg_space.sv
`timescale 1ns/1ps
module tb_hb_cfg_space;
  localparam int FN_W = 3;
  localparam time PER = 5ns;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            soft_rst;
  logic [FN_W-1:0] fn_sel;
  logic [7:0]      reg_addr;
  logic            wr_en;
  logic [7:0]      wr_data;
  logic [7:0]      rd_data;
  logic [23:0]     shadow_ctl;

  int total = 0;
  int bad = 0;
  logic [7:0] model [256];

  always #(PER/2) clk = ~clk;

  hb_cfg_space #(.FN_W(FN_W)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fn_sel(fn_sel),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .shadow_ctl(shadow_ctl)
  );

  function automatic logic [7:0] exp_default(input logic [7:0] a);
    case (a)
      8'h00: return 8'h06;  8'h01: return 8'h11;
      8'h02: return 8'h95;  8'h03: return 8'h15;
      8'h04: return 8'h07;  8'h06: return 8'hA0;
      8'h07: return 8'h02;  8'h08: return 8'h02;
      8'h0B: return 8'h06;  8'h52: return 8'h02;
      8'h58: return 8'h40;  8'h59: return 8'h05;
      8'h5A, 8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h5F: return 8'h01;
      8'h64: return 8'hAB;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit named_in_r1(input logic [7:0] a);
    return (a <= 8'h04) || a == 8'h06 || a == 8'h07 || a == 8'h08 ||
           a == 8'h0B || a == 8'h52 || (a >= 8'h58 && a <= 8'h5F) ||
           a == 8'h64;
  endfunction

  function automatic logic [7:0] exp_after_write(input logic [7:0] a,
                                                 input logic [7:0] old,
                                                 input logic [7:0] d);
    logic [7:0] m;
    case (a)
      8'h00, 8'h01, 8'h08, 8'h09, 8'h0A,
      8'h0B, 8'h0C, 8'h0E, 8'h0F: return old;
      8'h07: return old & ~(d & 8'hB0);
      8'h04: m = 8'h40;
      8'h65: m = 8'h20;  8'h66: m = 8'h05;  8'h67: m = 8'hC0;
      8'h68: m = 8'h40;  8'h6D: m = 8'h6F;  8'h70: m = 8'h01;
      8'h71: m = 8'h4E;  8'h73: m = 8'h0C;  8'h75: m = 8'hC7;
      default: m = 8'hFF;
    endcase
    return (old & ~m) | (d & m);
  endfunction

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp, input logic [7:0] a);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", req, a, act, exp);
    end
  endtask

  // one clock cycle of access, inputs set on falling edge
  task automatic cycle(input logic [7:0] a, input logic [7:0] d,
                       input logic we, input logic [FN_W-1:0] fn,
                       input logic srst);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = we; fn_sel = fn; soft_rst = srst;
    @(negedge clk);
    wr_en = 1'b0; soft_rst = 1'b0;
    if (we)   model[a] = exp_after_write(a, model[a], d);
    if (srst) model[8'h63] = model[8'h63] & ~8'h30;
  endtask

  task automatic read_chk(input string req, input logic [7:0] a,
                          input logic [FN_W-1:0] fn);
    reg_addr = a; fn_sel = fn; #1;
    check(req, rd_data, (fn != '0) ? 8'hFF : model[a], a);
  endtask

  task automatic shadow_chk();
    total++;
    if (shadow_ctl !== {model[8'h63], model[8'h62], model[8'h61]}) begin
      bad++;
      $display("FAIL R10 actual=%06h expected=%06h", shadow_ctl,
               {model[8'h63], model[8'h62], model[8'h61]});
    end
  endtask

  initial begin : watchdog
    #(PER * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] ra;
    logic [7:0] pm [10];
    void'($urandom(32'h5EED_0C0F));
    rst_n = 1'b0; soft_rst = 1'b0; fn_sel = '0; reg_addr = '0;
    wr_en = 1'b0; wr_data = '0;
    for (int i = 0; i < 256; i++) model[i] = exp_default(8'(i));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset image
    for (int i = 0; i < 256; i++)
      read_chk(named_in_r1(8'(i)) ? "R1" : "R2", 8'(i), '0);
    shadow_chk();

    // other functions read all-ones
    for (int f = 1; f < 8; f++) read_chk("R8", 8'h00, FN_W'(f));
    read_chk("R8", 8'h64, 3'd7);

    // read-only offsets
    foreach (pm[k]) pm[k] = 8'h00;
    begin
      logic [7:0] ro_list [9] = '{8'h00, 8'h01, 8'h08, 8'h09, 8'h0A,
                                  8'h0B, 8'h0C, 8'h0E, 8'h0F};
      foreach (ro_list[k]) begin
        cycle(ro_list[k], 8'hFF, 1'b1, '0, 1'b0);
        read_chk("R3", ro_list[k], '0);
        cycle(ro_list[k], 8'h5A, 1'b1, '0, 1'b0);
        read_chk("R3", ro_list[k], '0);
      end
    end

    // command bit 6 only
    cycle(8'h04, 8'hFF, 1'b1, '0, 1'b0);  read_chk("R4", 8'h04, '0);
    cycle(8'h04, 8'h00, 1'b1, '0, 1'b0);  read_chk("R4", 8'h04, '0);

    // status w1c: ones in other bits do not set, bit 1 kept
    cycle(8'h07, 8'hFF, 1'b1, '0, 1'b0);  read_chk("R5", 8'h07, '0);
    cycle(8'h07, 8'h4D, 1'b1, '0, 1'b0);  read_chk("R5", 8'h07, '0);

    // partial masks
    begin
      logic [7:0] pl [9] = '{8'h65, 8'h66, 8'h67, 8'h68, 8'h6D,
                             8'h70, 8'h71, 8'h73, 8'h75};
      foreach (pl[k]) begin
        cycle(pl[k], 8'hFF, 1'b1, '0, 1'b0);  read_chk("R6", pl[k], '0);
        cycle(pl[k], 8'h00, 1'b1, '0, 1'b0);  read_chk("R6", pl[k], '0);
        cycle(pl[k], 8'hA5, 1'b1, '0, 1'b0);  read_chk("R6", pl[k], '0);
      end
    end

    // full writes
    cycle(8'h40, 8'hC3, 1'b1, '0, 1'b0);  read_chk("R7", 8'h40, '0);
    cycle(8'h06, 8'h5A, 1'b1, '0, 1'b0);  read_chk("R7", 8'h06, '0);
    cycle(8'hFF, 8'h81, 1'b1, '0, 1'b0);  read_chk("R7", 8'hFF, '0);

    // function number not decoded on writes
    cycle(8'h41, 8'h3C, 1'b1, 3'd5, 1'b0); read_chk("R11", 8'h41, '0);

    // shadow bytes and soft reset
    cycle(8'h61, 8'h12, 1'b1, '0, 1'b0);
    cycle(8'h62, 8'h34, 1'b1, '0, 1'b0);
    cycle(8'h63, 8'hFF, 1'b1, '0, 1'b0);
    shadow_chk();
    cycle(8'h00, 8'h00, 1'b0, '0, 1'b1);
    read_chk("R9", 8'h63, '0);
    read_chk("R9", 8'h64, '0);
    read_chk("R9", 8'h61, '0);
    shadow_chk();
    cycle(8'h63, 8'h3C, 1'b1, '0, 1'b1);  read_chk("R9", 8'h63, '0);
    shadow_chk();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      logic [FN_W-1:0] fn;
      logic sr;
      if ($urandom_range(1, 0) == 1) begin
        case ($urandom_range(7, 0))
          0: a = 8'h04;  1: a = 8'h07;  2: a = 8'h63;
          3: a = 8'(8'h65 + $urandom_range(16, 0));
          4: a = 8'(8'h60 + $urandom_range(3, 0));
          default: a = 8'($urandom_range(15, 0));
        endcase
      end else a = 8'($urandom_range(255, 0));
      fn = ($urandom_range(3, 0) == 0) ? FN_W'($urandom_range(7, 1)) : '0;
      sr = ($urandom_range(15, 0) == 0);
      cycle(a, 8'($urandom_range(255, 0)), $urandom_range(3, 0) != 0, fn, sr);
      read_chk("R7", a, '0);
      ra = 8'($urandom_range(255, 0));
      read_chk("R8", ra, ($urandom_range(3, 0) == 0) ? 3'd2 : 3'd0);
      shadow_chk();
    end

    // final sweep
    for (int i = 0; i < 256; i++) read_chk("R7", 8'(i), '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule